// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel for an interval timer. It has a clock enable that marks count ticks and a gate input. Software-side logic, which is not part of this block, hands it a folded mode code and an initial count. The channel produces the visible count value and an output waveform, and the mode selects that waveform: a level that rises at terminal count, a gate-triggered one-shot, a periodic rate pulse, a square wave, or a strobe triggered by software or by the gate.

Time is tracked as ticks elapsed since the last load or restart. A reload phase and a double-speed phase run beside that tick count for the periodic modes. The output and count views are then simple functions of these values. Counting is binary only. The BCD flag that arrives with a mode write is stored and presented unchanged.

Top module: `interval_counter_channel`

## Requirements
- R1: After reset, out_o is 0, count_o is 0, bcd_o is 0. Ticks have no effect until a mode has been written and a count loaded.
- R2: A loaded value of 0 acts as an initial count of 65536. count_o reads 0x0000 in the cycle after the load and 0xFFFF after the first tick.
- R3: Mode codes 6 and 7 (binary 110 and 111) behave exactly like codes 2 and 3.
- R4: A mode write with no load in the same cycle stops counting and clears the elapsed ticks. out_o then sits at 0 for mode 0 and at 1 for every other mode. count_o shows the initial count until a load arrives.
- R5: In mode 0, out_o is 0 after a load, goes to 1 in the cycle after the tick at which elapsed ticks equal the count, and stays 1. count_o is the count minus elapsed ticks, modulo 2^16.
- R6: In modes 0 and 4, a low gate suspends counting. In modes 1, 2, 3 and 5, a gate rising edge on a loaded channel resets elapsed ticks to zero and does not suspend anything.
- R7: In mode 1, out_o is 0 while elapsed ticks are below the count and 1 from then on. count_o matches R5.
- R8: In mode 2, out_o is 1 when the elapsed ticks are a nonzero multiple of the count. count_o is the count minus (elapsed mod count).
- R9: In mode 3, out_o is 1 while (elapsed mod count) < (count+1)/2. count_o is the count minus ((2 x elapsed) mod count).
- R10: In modes 4 and 5, out_o is 1 only while elapsed ticks equal the count. It drops at the next counted tick. count_o matches R5.
- R11: A load resets the elapsed ticks in any mode. bcd_o takes bcd_in on each mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick enable |
| gate | input | 1 | Gate level |
| mode_wr | input | 1 | Mode write strobe |
| mode_code | input | 3 | Raw mode code (6/7 fold to 2/3) |
| bcd_in | input | 1 | BCD flag written with the mode |
| load | input | 1 | Count load strobe |
| load_val | input | 16 | Initial count (0 means 65536) |
| count_o | output | 16 | Visible count |
| out_o | output | 1 | Channel output waveform |
| bcd_o | output | 1 | Stored BCD flag |

## Verification
The bench uses the default 16-bit count width with GATE_INIT=0, which is the reset setting of a channel whose gate starts deasserted. Small initial counts (1 to 7) complete many periods of every mode within a short run. These small counts also reach the count-of-one edge in the square-wave phase. A zero load exercises the 65536 case and the 16-bit wrap of the visible count. GATE_INIT=0 makes the first gate high after reset a real rising edge, so restarts are tested from the very first cycle.

// File: rtl/ictr_pkg.sv
`timescale 1ns/1ps
package ictr_pkg;
  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTRB  = 3'd4,
    M_HWSTRB  = 3'd5
  } ictr_mode_e;

  // codes 110/111 land on 010/011
  function automatic ictr_mode_e fold_mode(input logic [2:0] code);
    if (code[2] && code[1]) return ictr_mode_e'({1'b0, code[1:0]});
    else                    return ictr_mode_e'(code);
  endfunction

  function automatic logic gate_is_level(input ictr_mode_e m);
    return (m == M_TERM) || (m == M_SWSTRB);
  endfunction
endpackage

// File: rtl/ictr_ctrl.sv
`timescale 1ns/1ps
module ictr_ctrl
  import ictr_pkg::*;
#(
  parameter int  CW        = 16,
  parameter bit  GATE_INIT = 1'b0,
  localparam int NW        = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_code,
  input  logic          bcd_in,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output ictr_mode_e    mode_q,
  output logic          bcd_q,
  output logic [NW-1:0] init_q,
  output logic          programmed_q,
  output logic          loaded_q,
  output logic          clr,
  output logic          adv
);
  ictr_mode_e    mode_d;
  logic          bcd_d, programmed_d, loaded_d, gate_q, rise;
  logic [NW-1:0] init_d;

  assign rise = gate & ~gate_q;

  always_comb begin
    mode_d       = mode_q;
    bcd_d        = bcd_q;
    init_d       = init_q;
    programmed_d = programmed_q;
    loaded_d     = loaded_q;
    if (mode_wr) begin
      mode_d       = fold_mode(mode_code);
      bcd_d        = bcd_in;
      programmed_d = 1'b1;
      loaded_d     = 1'b0;
    end
    if (load) begin
      init_d   = (load_val == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_val};
      loaded_d = 1'b1;
    end
  end

  always_comb begin
    clr = mode_wr | load | (loaded_q & rise & ~gate_is_level(mode_q));
    adv = ~clr & programmed_q & loaded_q & tick_en & (gate | ~gate_is_level(mode_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= M_TERM;
      bcd_q        <= 1'b0;
      init_q       <= {1'b1, {CW{1'b0}}};
      programmed_q <= 1'b0;
      loaded_q     <= 1'b0;
      gate_q       <= GATE_INIT;
    end else begin
      mode_q       <= mode_d;
      bcd_q        <= bcd_d;
      init_q       <= init_d;
      programmed_q <= programmed_d;
      loaded_q     <= loaded_d;
      gate_q       <= gate;
    end
  end
endmodule

// File: rtl/ictr_track.sv
`timescale 1ns/1ps
module ictr_track #(
  parameter int  CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [NW-1:0] init,
  output logic [NW-1:0] elapsed_q,
  output logic [NW-1:0] phase_q,
  output logic [NW-1:0] dphase_q,
  output logic          reached_q,
  output logic          passed_q,
  output logic          started_q
);
  logic [NW-1:0] elapsed_d, phase_d, dphase_d, elapsed_inc, phase_inc;
  logic [NW:0]   dsum;
  logic          reached_d, passed_d, started_d;

  assign elapsed_inc = elapsed_q + 1'b1;
  assign phase_inc   = phase_q + 1'b1;
  assign dsum        = {1'b0, dphase_q} + 2'd2;

  always_comb begin
    elapsed_d = elapsed_q;
    phase_d   = phase_q;
    dphase_d  = dphase_q;
    reached_d = reached_q;
    passed_d  = passed_q;
    started_d = started_q;
    if (clr) begin
      elapsed_d = '0;
      phase_d   = '0;
      dphase_d  = '0;
      reached_d = 1'b0;
      passed_d  = 1'b0;
      started_d = 1'b0;
    end else if (adv) begin
      elapsed_d = elapsed_inc;
      phase_d   = (phase_inc == init) ? '0 : phase_inc;
      if (init == NW'(1))               dphase_d = '0;
      else if (dsum >= {1'b0, init})    dphase_d = NW'(dsum - {1'b0, init});
      else                              dphase_d = dsum[NW-1:0];
      reached_d = reached_q | (elapsed_inc == init);
      passed_d  = passed_q | reached_q;
      started_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      phase_q   <= '0;
      dphase_q  <= '0;
      reached_q <= 1'b0;
      passed_q  <= 1'b0;
      started_q <= 1'b0;
    end else begin
      elapsed_q <= elapsed_d;
      phase_q   <= phase_d;
      dphase_q  <= dphase_d;
      reached_q <= reached_d;
      passed_q  <= passed_d;
      started_q <= started_d;
    end
  end
endmodule

// File: rtl/ictr_view.sv
`timescale 1ns/1ps
module ictr_view
  import ictr_pkg::*;
#(
  parameter int  CW = 16,
  localparam int NW = CW + 1
) (
  input  ictr_mode_e    mode,
  input  logic          programmed,
  input  logic          loaded,
  input  logic [NW-1:0] init,
  input  logic [NW-1:0] elapsed,
  input  logic [NW-1:0] phase,
  input  logic [NW-1:0] dphase,
  input  logic          reached,
  input  logic          passed,
  input  logic          started,
  output logic [CW-1:0] count,
  output logic          out
);
  logic [NW-1:0] rem_lin, rem_rate, rem_sq;
  logic [NW:0]   half;
  logic          wave;

  assign rem_lin  = init - elapsed;
  assign rem_rate = init - phase;
  assign rem_sq   = init - dphase;
  assign half     = ({1'b0, init} + 1'b1) >> 1;

  always_comb begin
    unique case (mode)
      M_RATE:   begin count = rem_rate[CW-1:0]; wave = started & (phase == '0); end
      M_SQUARE: begin count = rem_sq[CW-1:0];   wave = ({1'b0, phase} < half); end
      M_SWSTRB,
      M_HWSTRB: begin count = rem_lin[CW-1:0];  wave = reached & ~passed; end
      default:  begin count = rem_lin[CW-1:0];  wave = reached; end
    endcase
    if (!programmed)  out = 1'b0;
    else if (!loaded) out = (mode != M_TERM);
    else              out = wave;
  end
endmodule

// File: rtl/interval_counter_channel.sv
`timescale 1ns/1ps
module interval_counter_channel
  import ictr_pkg::*;
#(
  parameter int  CW        = 16,
  parameter bit  GATE_INIT = 1'b0,
  localparam int NW        = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          mode_wr,
  input  logic [2:0]    mode_code,
  input  logic          bcd_in,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count_o,
  output logic          out_o,
  output logic          bcd_o
);
  ictr_mode_e    mode_q;
  logic [NW-1:0] init_q, elapsed_q, phase_q, dphase_q;
  logic          programmed_q, loaded_q, clr, adv;
  logic          reached_q, passed_q, started_q;

  ictr_ctrl #(.CW(CW), .GATE_INIT(GATE_INIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .mode_wr(mode_wr), .mode_code(mode_code), .bcd_in(bcd_in),
    .load(load), .load_val(load_val), .mode_q(mode_q), .bcd_q(bcd_o),
    .init_q(init_q), .programmed_q(programmed_q), .loaded_q(loaded_q),
    .clr(clr), .adv(adv)
  );

  ictr_track #(.CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .init(init_q),
    .elapsed_q(elapsed_q), .phase_q(phase_q), .dphase_q(dphase_q),
    .reached_q(reached_q), .passed_q(passed_q), .started_q(started_q)
  );

  ictr_view #(.CW(CW)) u_view (
    .mode(mode_q), .programmed(programmed_q), .loaded(loaded_q),
    .init(init_q), .elapsed(elapsed_q), .phase(phase_q), .dphase(dphase_q),
    .reached(reached_q), .passed(passed_q), .started(started_q),
    .count(count_o), .out(out_o)
  );

  // R1: nothing drives the output before a mode exists
  p_quiet_unprogrammed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !programmed_q |-> !out_o);

  // R2: zero load reads back as the wrapped 65536
  p_zero_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (count_o == '0));

  // R3: folded mode never leaves the legal range
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    programmed_q |-> (mode_q <= M_HWSTRB));

  // R4: idle level after a bare mode write
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !load) |=> (out_o == (mode_q != M_TERM)));

  // R5: terminal-count level is sticky
  p_term_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && mode_q == M_TERM && out_o && !mode_wr && !load) |=> out_o);

  // R6: low gate freezes the level-gated modes
  p_gate_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && gate_is_level(mode_q) && !gate && !mode_wr && !load)
      |=> $stable(count_o));

  // R10: strobe ends at the next counted tick
  p_strobe_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_SWSTRB || mode_q == M_HWSTRB) && out_o && adv) |=> !out_o);
endmodule

// File: tb/sim_interval_counter_channel.sv
`timescale 1ns/1ps
module sim_interval_counter_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate = 1'b0, mode_wr = 1'b0, bcd_in = 1'b0, load = 1'b0;
  logic [2:0]  mode_code = 3'd0;
  logic [15:0] load_val = 16'd0;
  logic [15:0] count_o;
  logic        out_o, bcd_o;

  int    n_checks = 0, n_errors = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2.5 clk = ~clk;

  interval_counter_channel #(.CW(16), .GATE_INIT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .mode_wr(mode_wr), .mode_code(mode_code), .bcd_in(bcd_in),
    .load(load), .load_val(load_val), .count_o(count_o),
    .out_o(out_o), .bcd_o(bcd_o)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: unbounded elapsed count, modulo arithmetic
  int m_n = 65536, m_d = 0, m_mode = 0;
  bit m_prog = 0, m_loaded = 0, m_gprev = 0, m_bcd = 0;

  function automatic int fold(int c);
    case (c)
      6: return 2;
      7: return 3;
      default: return c;
    endcase
  endfunction

  function automatic int exp_count();
    int v;
    case (m_mode)
      2: v = m_n - (m_d % m_n);
      3: v = m_n - ((2 * m_d) % m_n);
      default: v = m_n - m_d;
    endcase
    return v & 16'hFFFF;
  endfunction

  function automatic int exp_out();
    if (!m_prog) return 0;
    if (!m_loaded) return (m_mode != 0) ? 1 : 0;
    case (m_mode)
      0, 1: return (m_d >= m_n) ? 1 : 0;
      2: return (m_d != 0 && (m_d % m_n) == 0) ? 1 : 0;
      3: return ((m_d % m_n) < (m_n + 1) / 2) ? 1 : 0;
      default: return (m_d == m_n) ? 1 : 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rise, lvl;
    if (!rst_n) begin
      m_n = 65536; m_d = 0; m_mode = 0; m_prog = 0; m_loaded = 0; m_gprev = 0; m_bcd = 0;
    end else begin
      rise = gate && !m_gprev;
      m_gprev = gate;
      lvl = (m_mode == 0 || m_mode == 4);
      if (mode_wr) begin
        m_mode = fold(int'(mode_code)); m_bcd = bcd_in; m_prog = 1; m_loaded = 0; m_d = 0;
      end
      if (load) begin
        m_n = (load_val == 0) ? 65536 : int'(load_val); m_loaded = 1; m_d = 0;
      end
      if (!mode_wr && !load) begin
        if (m_loaded && rise && !lvl) m_d = 0;
        else if (m_prog && m_loaded && tick_en && (gate || !lvl)) m_d++;
      end
    end
    #1;
    if (rst_n) begin
      check(cur_req, "count_o", int'(count_o), exp_count());
      check(cur_req, "out_o", int'(out_o), exp_out());
      check("R11", "bcd_o", int'(bcd_o), int'(m_bcd));
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    mode_wr = 1'b0;
    load = 1'b0;
  endtask

  task automatic set_mode(int code, bit b);
    mode_code = 3'(code); bcd_in = b; mode_wr = 1'b1;
    cyc();
  endtask

  task automatic do_load(int v);
    load_val = 16'(v); load = 1'b1;
    cyc();
  endtask

  task automatic run(int n, int every);
    for (int i = 0; i < n; i++) begin
      tick_en = ((i % every) == 0);
      cyc();
    end
    tick_en = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset out_o", int'(out_o), 0);
    check("R1", "reset count_o", int'(count_o), 0);
    check("R1", "reset bcd_o", int'(bcd_o), 0);
    rst_n = 1'b1;
    run(4, 1);

    cur_req = "R4";
    set_mode(1, 0);
    check("R4", "idle out mode1", int'(out_o), 1);
    run(5, 1);
    set_mode(0, 0);
    check("R4", "idle out mode0", int'(out_o), 0);
    run(3, 1);

    cur_req = "R5";
    gate = 1'b1;
    do_load(5);
    run(4, 1);
    cur_req = "R6";
    gate = 1'b0;
    run(4, 1);
    gate = 1'b1;
    cur_req = "R5";
    run(9, 1);

    cur_req = "R7";
    set_mode(1, 0);
    do_load(4);
    run(7, 1);
    cur_req = "R6";
    gate = 1'b0; cyc(); gate = 1'b1;
    run(7, 1);

    cur_req = "R8";
    set_mode(2, 0);
    do_load(3);
    run(14, 2);
    do_load(1);
    run(4, 1);

    cur_req = "R9";
    set_mode(3, 0);
    do_load(5);
    run(14, 1);
    do_load(4);
    run(10, 1);
    do_load(1);
    run(3, 1);

    cur_req = "R3";
    set_mode(6, 0);
    do_load(3);
    run(8, 1);
    set_mode(7, 0);
    do_load(4);
    run(9, 1);

    cur_req = "R10";
    set_mode(4, 0);
    do_load(3);
    run(3, 1);
    gate = 1'b0;
    run(3, 1);
    gate = 1'b1;
    run(4, 2);
    set_mode(5, 0);
    do_load(2);
    run(4, 1);
    gate = 1'b0; cyc(); gate = 1'b1;
    run(5, 1);

    cur_req = "R2";
    set_mode(0, 1);
    do_load(0);
    check("R2", "count after zero load", int'(count_o), 0);
    tick_en = 1'b1; cyc(); tick_en = 1'b0;
    check("R2", "count after first tick", int'(count_o), 16'hFFFF);
    run(3, 1);

    cur_req = "R11";
    check("R11", "bcd carried", int'(bcd_o), 1);
    set_mode(1, 0);
    do_load(6);
    run(3, 1);
    do_load(6);
    check("R11", "reload resets", int'(count_o), 6);
    run(8, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule